// File: doc/BRIEF.md
# Fractional Microsecond Timebase

The block derives a one-microsecond tick from a fixed reference clock and keeps a free-running upward counter of those ticks. The tick rate is set by a fraction held in a configuration register, a dividend over a divisor, so reference frequencies that are not a whole number of megahertz still give exact 1 MHz ticks on average.

Each reference clock adds the dividend to an accumulator. When the sum reaches or passes the divisor, a tick is produced and the divisor is subtracted, keeping the remainder. For example, a 19.2 MHz reference uses 5/96, and a 12 MHz reference uses 1/12.

A simple register port gives read access to the counter. It also gives read and write access to the ratio and to a freeze control, so software can save the ratio and restore it after a power cycle.

Top module: `usec_timebase`

## Requirements
- R1: After reset the counter is 0, the ratio register holds 0x000b (dividend 1, divisor 12), freeze is 0, tick_o is 0 and rdata_o is 0.
- R2: The ratio register keeps dividend−1 in bits 15:8 and divisor−1 in bits 7:0. When the dividend is less than the divisor, each clock adds the dividend to an accumulator. Whenever the sum is at least the divisor, tick_o is high in the next cycle and the divisor is subtracted from the sum. This gives exactly dividend ticks per divisor clocks.
- R3: The counter (count_o) rises by exactly one in the cycle after each cycle in which tick_o is high and freeze is clear. It never changes otherwise.
- R4: When the dividend is equal to or larger than the divisor, tick_o is high on every cycle and the accumulator stays at zero.
- R5: A write to the ratio register at offset 0x14 clears the accumulator. tick_o is low in the cycle after the write, and the new ratio governs the ticks from the next clock on.
- R6: A read of offset 0x14 returns bits 15:0 exactly as last written, with bits 31:16 read as zero.
- R7: Bit 0 of offset 0x4c is the freeze control, and it reads back at offset 0x4c. While it is set the counter holds its value, but the accumulator and tick_o keep running.
- R8: The counter wraps from its all-ones value to 0 with no other effect.
- R9: Offset 0x10 returns the counter, zero-extended. Writes to offset 0x10 are ignored.
- R10: Read data appears on rdata_o in the cycle after a read request, and is 0 in every other cycle. Reads of unmapped offsets return 0, and writes to unmapped offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| tick_o | output | 1 | One-cycle microsecond tick |
| count_o | output | CNT_W | Microsecond counter |

## Verification
The assertions assume each request is held for a single cycle. They also assume the ratio is changed only through a register write, so each cycle's tick depends only on the ratio held and on the accumulator. The bench drives every request for exactly one clock, separated by idle cycles. It applies several ratios: below-unity ratios for common reference rates, ratios equal to unity and above it, and a ratio written with garbage in its upper bits. A second instance with an 8-bit counter wraps within the run, while the bus sequence covers writes to the counter, unmapped offsets and the freeze control.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;
  localparam int unsigned FRAC_W = 8;
  localparam int unsigned CFG_W  = 2 * FRAC_W;

  localparam logic [7:0] OFS_COUNT  = 8'h10;
  localparam logic [7:0] OFS_RATIO  = 8'h14;
  localparam logic [7:0] OFS_FREEZE = 8'h4c;

  localparam logic [CFG_W-1:0] RATIO_RESET = 16'h000b;

  typedef struct packed {
    logic [FRAC_W-1:0] num_m1;
    logic [FRAC_W-1:0] den_m1;
  } ratio_t;
endpackage

// File: rtl/usec_prescaler.sv
module usec_prescaler
  import usec_timebase_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t ratio_i,
  input  logic   clear_i,
  output logic   tick_o
);
  localparam int unsigned ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0] num, den, acc_q, acc_d, sum;
  logic             tick_d, tick_q;

  always_comb begin
    num = {1'b0, ratio_i.num_m1} + ACC_W'(1);
    den = {1'b0, ratio_i.den_m1} + ACC_W'(1);
    sum = acc_q + num;
    if (clear_i) begin
      acc_d  = '0;
      tick_d = 1'b0;
    end else if (num >= den) begin
      // at most one tick per clock: saturate
      acc_d  = '0;
      tick_d = 1'b1;
    end else if (sum >= den) begin
      acc_d  = sum - den;
      tick_d = 1'b1;
    end else begin
      acc_d  = sum;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (step_i && !hold_i) cnt_q <= cnt_q + CNT_W'(1); // silent wrap
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/usec_regs.sv
module usec_regs
  import usec_timebase_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output ratio_t            ratio_o,
  output logic              freeze_o,
  output logic              ratio_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CFG_W-1:0]  ratio_q;
  logic              freeze_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              hit_cnt, hit_ratio, hit_frz, wr, rd;

  always_comb begin
    hit_cnt   = (addr_i == ADDR_W'(OFS_COUNT));
    hit_ratio = (addr_i == ADDR_W'(OFS_RATIO));
    hit_frz   = (addr_i == ADDR_W'(OFS_FREEZE));
    wr        = req_i && we_i;
    rd        = req_i && !we_i;
    rdata_d   = '0;
    if (rd) begin
      unique case (1'b1)
        hit_cnt:   rdata_d = DATA_W'(count_i);
        hit_ratio: rdata_d = DATA_W'(ratio_q);
        hit_frz:   rdata_d = DATA_W'(freeze_q);
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q  <= RATIO_RESET;
      freeze_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rdata_q <= rdata_d;
      if (wr && hit_ratio) ratio_q  <= wdata_i[CFG_W-1:0];
      if (wr && hit_frz)   freeze_q <= wdata_i[0];
    end
  end

  assign ratio_o    = ratio_t'(ratio_q);
  assign freeze_o   = freeze_q;
  assign ratio_wr_o = wr && hit_ratio;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_timebase_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tick_o,
  output logic [CNT_W-1:0]  count_o
);
  ratio_t ratio;
  logic   freeze_q;
  logic   ratio_wr;

  usec_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .count_i    (count_o),
    .ratio_o    (ratio),
    .freeze_o   (freeze_q),
    .ratio_wr_o (ratio_wr),
    .rdata_o    (rdata_o)
  );

  usec_prescaler u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio),
    .clear_i (ratio_wr),
    .tick_o  (tick_o)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tick_o),
    .hold_i  (freeze_q),
    .count_o (count_o)
  );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk
  import usec_timebase_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              tick_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              freeze_q,
  input logic              ratio_wr
);
  logic unmapped_rd;
  assign unmapped_rd = req_i && !we_i &&
                       addr_i != ADDR_W'(OFS_COUNT) &&
                       addr_i != ADDR_W'(OFS_RATIO) &&
                       addr_i != ADDR_W'(OFS_FREEZE);

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)));

  a_r3_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(count_o));

  a_r7_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_q |=> $stable(count_o));

  a_r5_wr_kills_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_wr |=> !tick_o);

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_rd |=> rdata_o == '0);

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> rdata_o == '0);
endmodule

bind usec_timebase usec_timebase_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .tick_o   (tick_o),
  .count_o  (count_o),
  .freeze_q (freeze_q),
  .ratio_wr (ratio_wr)
);

// File: tb/usec_timebase_bench.sv
`timescale 1ns/1ps
module usec_timebase_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, rdata_n;
  logic        tick_o, tick_n;
  logic [31:0] count_o;
  logic [7:0]  count_n;

  always #2.5 clk_i = ~clk_i;

  usec_timebase u_usec_timebase (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_o(tick_o), .count_o(count_o)
  );

  usec_timebase #(.CNT_W(8)) u_usec_timebase_w8 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_n), .tick_o(tick_n), .count_o(count_n)
  );

  // behavioural reference
  int unsigned m_ratio, m_acc, m_rdata;
  longint      m_ticks;
  bit          m_tick, m_frz;
  int          vectors = 0, errors = 0;
  string       tag = "R1";
  bit          live = 1'b0;
  bit          seen_wrap = 1'b0;
  logic [7:0]  prev_n = '0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ratio = 32'h000b; m_acc = 0; m_rdata = 0;
      m_ticks = 0; m_tick = 1'b0; m_frz = 1'b0;
    end else begin
      int unsigned dv, qv, s, n_rd, n_acc;
      bit n_tick;
      dv = ((m_ratio >> 8) & 8'hff) + 1;
      qv = (m_ratio & 8'hff) + 1;
      n_rd = 0;
      if (req_i && !we_i) begin
        if (addr_i == 8'h10)      n_rd = 32'(m_ticks);
        else if (addr_i == 8'h14) n_rd = m_ratio;
        else if (addr_i == 8'h4c) n_rd = 32'(m_frz);
      end
      if (req_i && we_i && addr_i == 8'h14) begin
        n_acc = 0; n_tick = 1'b0;
      end else if (dv >= qv) begin
        n_acc = 0; n_tick = 1'b1;
      end else begin
        s = m_acc + dv;
        n_tick = (s >= qv);
        n_acc  = n_tick ? s - qv : s;
      end
      if (m_tick && !m_frz) m_ticks = m_ticks + 1;
      if (req_i && we_i && addr_i == 8'h14) m_ratio = wdata_i & 32'hffff;
      if (req_i && we_i && addr_i == 8'h4c) m_frz = wdata_i[0];
      m_acc = n_acc; m_tick = n_tick; m_rdata = n_rd;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (live) begin
      check(tag, "count_o", count_o, m_ticks & 64'hffff_ffff);
      check(tag, "tick_o", tick_o, m_tick);
      check(tag, "rdata_o", rdata_o, m_rdata);
      check("R8", "narrow count", count_n, m_ticks & 64'hff);
      if (count_n < prev_n) seen_wrap = 1'b1;
      prev_n = count_n;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic access(bit w, logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1: reset state checked directly
    check("R1", "count at reset", count_o, 0);
    check("R1", "tick at reset", tick_o, 0);
    check("R1", "rdata at reset", rdata_o, 0);
    rst_ni = 1'b1;
    live = 1'b1;
    tag = "R1"; access(0, 8'h14, 0); access(0, 8'h4c, 0);
    tag = "R2"; idle(200); access(0, 8'h10, 0);
    tag = "R5"; access(1, 8'h14, 32'h045f); idle(400);
    tag = "R2"; access(1, 8'h14, 32'h0019); idle(150);
    access(1, 8'h14, 32'h000c); idle(60); access(0, 8'h10, 0);
    tag = "R4"; access(1, 8'h14, 32'h0303); idle(150);
    access(1, 8'h14, 32'h0502); idle(150);
    tag = "R6"; access(1, 8'h14, 32'hABCD_1234); access(0, 8'h14, 0); idle(80);
    tag = "R7"; access(1, 8'h4c, 32'h1); access(0, 8'h4c, 0); idle(100);
    access(0, 8'h10, 0); access(1, 8'h4c, 32'h0); idle(20);
    tag = "R9"; access(1, 8'h10, 32'hdead_beef); access(0, 8'h10, 0);
    tag = "R10"; access(0, 8'h20, 0); access(1, 8'h20, 32'hffff_ffff);
    access(1, 8'h14, 32'h0000); idle(300);
    access(0, 8'h14, 0); access(0, 8'h4c, 0); idle(5);
    tag = "R3"; access(1, 8'h14, 32'h0104); idle(50);
    live = 1'b0;
    check("R8", "narrow counter wrapped", seen_wrap, 1);
    finish_run();
  end
endmodule